// File: doc/BRIEF.md
# Thermal Limit Alert with Fault Queue

This block watches a stream of finished temperature samples (12-bit two's complement, 1/16 °C per LSB) and decides when a thermal alert is raised. Each sample arriving with its valid strobe is compared at full width against a programmable high limit and a low limit. A consecutive-fault counter requires 1, 2, 4 or 6 qualifying samples in a row before the alert changes state, so isolated noisy readings are filtered out.

Two behaviours are offered. In comparator mode the alert is a level with hysteresis: it sets at or above the high limit and releases below the low limit. In interrupt mode the alert is a latched event. It is cleared by any register read, by a won alert-response arbitration, or by entering shutdown. It then re-arms on the opposite limit, so high and low events alternate. The output pin polarity is programmable. A read-back status bit always shows comparator behaviour, with the same polarity inversion. A cause flag tells which limit raised the pending interrupt, for the alert-response address byte.

Top module: `thermal_alert`

## Requirements
- R1: After reset, with polarity 0, the alert pin is 1 (inactive), the status bit reads 1 and the cause flag is 0.
- R2: Fault-queue code 0, 1, 2 and 3 require 1, 2, 4 and 6 consecutive qualifying samples, respectively, before the alert changes state.
- R3: A sample that fails the watched condition resets the consecutive count. Clock cycles without the sample-valid strobe neither count nor reset it.
- R4: Comparisons are signed two's complement over all 12 bits. A sample equal to the high limit qualifies, a sample equal to the low limit does not, and a single LSB of a limit changes the outcome.
- R5: In comparator mode the alert, once set, stays set through samples between the limits. It clears only after the queued number of samples below the low limit.
- R6: In interrupt mode the alert sets after the queued number of samples at or above the high limit. It holds until a register-read or alert-response-won pulse. Afterwards it re-arms only on the low-limit condition, and the two conditions alternate. Samples are ignored while an interrupt is pending.
- R7: In interrupt mode a rising edge of the shutdown input clears a pending alert. It does not change which limit is armed next.
- R8: The cause flag is 1 when the pending interrupt came from the high limit and 0 when it came from the low limit.
- R9: With polarity 0 the alert pin is active low. With polarity 1 it is active high, and the status bit is inverted in the same way (status = comparator state when polarity is 1, its complement when polarity is 0).
- R10: The status bit follows comparator-mode behaviour whatever the mode input. A register read that clears an interrupt leaves it unchanged.
- R11: A general-call reset pulse clears the alert, the status, the cause flag and the counters. In interrupt mode the high limit is armed again afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gc_reset | input | 1 | General-call reset pulse, synchronous clear |
| sample_valid | input | 1 | Strobe: a new conversion result is on `sample` |
| sample | input | 12 | Temperature, two's complement, 1/16 °C |
| limit_hi | input | 12 | High limit, same format |
| limit_lo | input | 12 | Low limit, same format |
| int_mode | input | 1 | 0 comparator, 1 interrupt |
| polarity | input | 1 | 0 active-low pin, 1 active-high pin |
| fq_code | input | 2 | Fault-queue depth code |
| reg_read | input | 1 | Pulse: any register was read |
| ar_won | input | 1 | Pulse: alert-response arbitration won |
| shutdown | input | 1 | Shutdown mode level |
| alert_pin | output | 1 | Alert output level |
| status_rd | output | 1 | Status bit for read-back |
| int_cause | output | 1 | Limit behind the pending interrupt: 1 high, 0 low |

## Verification
The bench builds the block with its default 12-bit sample width, so it can place the most negative code against a negative limit, where unsigned arithmetic would give the wrong answer. It can also step a limit by one LSB on either side of a sample. The fault-queue code is an input, so all four depths, including the six-sample queue broken up by a non-qualifying sample and by idle cycles, are reached in one run. The interrupt sequence walks a full high/low alternation. Each of the three clearing sources is applied, followed by a general-call reset.

// File: rtl/thermal_alert_pkg.sv
package thermal_alert_pkg;

  localparam int FQ_W  = 2;
  localparam int CNT_W = 3;

  typedef enum logic {
    WATCH_HIGH = 1'b0,
    WATCH_LOW  = 1'b1
  } watch_e;

  // consecutive samples needed per fault-queue code
  function automatic logic [CNT_W-1:0] fq_need(input logic [FQ_W-1:0] code);
    logic [CNT_W-1:0] n;
    case (code)
      2'd0:    n = 3'd1;
      2'd1:    n = 3'd2;
      2'd2:    n = 3'd4;
      default: n = 3'd6;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/thermal_alert_queue.sv
module thermal_alert_queue
  import thermal_alert_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic             hit,
  input  logic [CNT_W-1:0] need,
  output logic             fire
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = cnt + 1'b1;
  assign fire    = step && hit && (cnt_inc >= need);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr || fire || (step && !hit)) begin
      cnt <= '0;
    end else if (step && hit) begin
      cnt <= cnt_inc;
    end
  end

endmodule

// File: rtl/thermal_alert_comp.sv
module thermal_alert_comp
  import thermal_alert_pkg::*;
#(
  parameter int TEMP_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  input  logic [TEMP_W-1:0] sample,
  input  logic [TEMP_W-1:0] limit_hi,
  input  logic [TEMP_W-1:0] limit_lo,
  input  logic [CNT_W-1:0]  need,
  output logic              active,
  output logic              fire
);

  function automatic logic at_or_above(input logic [TEMP_W-1:0] a,
                                       input logic [TEMP_W-1:0] b);
    return $signed(a) >= $signed(b);
  endfunction

  logic hit;

  assign hit = active ? !at_or_above(sample, limit_lo)
                      :  at_or_above(sample, limit_hi);

  thermal_alert_queue u_queue (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr),
    .step (step),
    .hit  (hit),
    .need (need),
    .fire (fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
    end else if (clr) begin
      active <= 1'b0;
    end else if (fire) begin
      active <= !active;
    end
  end

endmodule

// File: rtl/thermal_alert_intr.sv
module thermal_alert_intr
  import thermal_alert_pkg::*;
#(
  parameter int TEMP_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              clear_evt,
  input  logic              step,
  input  logic [TEMP_W-1:0] sample,
  input  logic [TEMP_W-1:0] limit_hi,
  input  logic [TEMP_W-1:0] limit_lo,
  input  logic [CNT_W-1:0]  need,
  output logic              pending,
  output logic              cause,
  output logic              dir,
  output logic              fire
);

  function automatic logic at_or_above(input logic [TEMP_W-1:0] a,
                                       input logic [TEMP_W-1:0] b);
    return $signed(a) >= $signed(b);
  endfunction

  watch_e watch;
  logic   hit;

  assign dir = watch;
  assign hit = (watch == WATCH_LOW) ? !at_or_above(sample, limit_lo)
                                    :  at_or_above(sample, limit_hi);

  thermal_alert_queue u_queue (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (hold || pending),
    .step (step && !pending),
    .hit  (hit),
    .need (need),
    .fire (fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      cause   <= 1'b0;
      watch   <= WATCH_HIGH;
    end else if (hold) begin
      pending <= 1'b0;
      cause   <= 1'b0;
      watch   <= WATCH_HIGH;
    end else if (fire) begin
      pending <= 1'b1;
      cause   <= (watch == WATCH_HIGH);
      watch   <= (watch == WATCH_HIGH) ? WATCH_LOW : WATCH_HIGH;
    end else if (clear_evt) begin
      pending <= 1'b0;
    end
  end

endmodule

// File: rtl/thermal_alert.sv
module thermal_alert
  import thermal_alert_pkg::*;
#(
  parameter int TEMP_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gc_reset,
  input  logic              sample_valid,
  input  logic [TEMP_W-1:0] sample,
  input  logic [TEMP_W-1:0] limit_hi,
  input  logic [TEMP_W-1:0] limit_lo,
  input  logic              int_mode,
  input  logic              polarity,
  input  logic [FQ_W-1:0]   fq_code,
  input  logic              reg_read,
  input  logic              ar_won,
  input  logic              shutdown,
  output logic              alert_pin,
  output logic              status_rd,
  output logic              int_cause
);

  logic [CNT_W-1:0] need;
  logic             sd_q;
  logic             sd_enter;
  logic             comp_active;
  logic             comp_fire;
  logic             int_pending;
  logic             int_fire;
  logic             int_dir;
  logic             alert_active;

  assign need     = fq_need(fq_code);
  assign sd_enter = shutdown && !sd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sd_q <= 1'b0;
    else        sd_q <= shutdown;
  end

  thermal_alert_comp #(.TEMP_W(TEMP_W)) u_comp (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (gc_reset),
    .step    (sample_valid),
    .sample  (sample),
    .limit_hi(limit_hi),
    .limit_lo(limit_lo),
    .need    (need),
    .active  (comp_active),
    .fire    (comp_fire)
  );

  thermal_alert_intr #(.TEMP_W(TEMP_W)) u_intr (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (gc_reset || !int_mode),
    .clear_evt(reg_read || ar_won || sd_enter),
    .step     (sample_valid),
    .sample   (sample),
    .limit_hi (limit_hi),
    .limit_lo (limit_lo),
    .need     (need),
    .pending  (int_pending),
    .cause    (int_cause),
    .dir      (int_dir),
    .fire     (int_fire)
  );

  assign alert_active = int_mode ? int_pending : comp_active;
  assign alert_pin    = polarity ? alert_active : !alert_active;
  assign status_rd    = polarity ? comp_active  : !comp_active;

endmodule

// File: rtl/thermal_alert_checker.sv
module thermal_alert_checker (
  input logic clk,
  input logic rst_n,
  input logic gc_reset,
  input logic sample_valid,
  input logic int_mode,
  input logic reg_read,
  input logic ar_won,
  input logic sd_enter,
  input logic comp_active,
  input logic comp_fire,
  input logic int_pending,
  input logic int_fire,
  input logic int_dir,
  input logic int_cause
);

  AST_COMP_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    comp_fire |-> sample_valid); // R3

  AST_COMP_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_valid && !gc_reset) |=> $stable(comp_active)); // R3

  AST_INT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (int_fire && int_mode && !gc_reset) |=> int_pending); // R6

  AST_INT_CLEARS_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_read || ar_won) && !int_fire) |=> !int_pending); // R6

  AST_INT_CLEARS_ON_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_enter && !int_fire) |=> !int_pending); // R7

  AST_CAUSE_MATCHES_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (int_fire && int_mode && !gc_reset) |=> (int_cause == !$past(int_dir))); // R8

  AST_GC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    gc_reset |=> (!comp_active && !int_pending && !int_cause)); // R11

endmodule

bind thermal_alert thermal_alert_checker u_chk (.*);

// File: tb/thermal_alert_bench.sv
module thermal_alert_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gc_reset = 1'b0;
  logic        sample_valid = 1'b0;
  logic [11:0] sample = '0;
  logic [11:0] limit_hi = 12'h500;
  logic [11:0] limit_lo = 12'h4B0;
  logic        int_mode = 1'b0;
  logic        polarity = 1'b0;
  logic [1:0]  fq_code = 2'd0;
  logic        reg_read = 1'b0;
  logic        ar_won = 1'b0;
  logic        shutdown = 1'b0;
  logic        alert_pin;
  logic        status_rd;
  logic        int_cause;

  always #2 clk = ~clk;

  thermal_alert u_thermal_alert (.*);

  typedef struct {
    logic  pin;
    logic  stat;
    logic  cause;
    logic  chk_cause;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 1'b0;

  // monitor: compare each expectation at the falling edge after its clock edge
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_checks++;
      if (alert_pin !== e.pin || status_rd !== e.stat ||
          (e.chk_cause && int_cause !== e.cause)) begin
        n_fail++;
        $display("FAIL %s: pin/stat/cause got %b/%b/%b expected %b/%b/%b",
                 e.req, alert_pin, status_rd, int_cause, e.pin, e.stat, e.cause);
      end
    end
  end

  task automatic cyc(input logic v, input logic [11:0] t, input logic rd,
                     input logic aw, input logic gc, input logic ep,
                     input logic es, input logic ec, input logic cc,
                     input string req);
    exp_t e;
    sample_valid = v;
    sample       = t;
    reg_read     = rd;
    ar_won       = aw;
    gc_reset     = gc;
    @(posedge clk);
    #1;
    sample_valid = 1'b0;
    reg_read     = 1'b0;
    ar_won       = 1'b0;
    gc_reset     = 1'b0;
    e.pin = ep; e.stat = es; e.cause = ec; e.chk_cause = cc; e.req = req;
    exp_q.push_back(e);
    @(negedge clk);
    #1;
  endtask

  task automatic smp(input logic [11:0] t, input logic ep, input logic es,
                     input string req);
    cyc(1'b1, t, 1'b0, 1'b0, 1'b0, ep, es, 1'b0, 1'b0, req);
  endtask

  task automatic smpc(input logic [11:0] t, input logic ep, input logic es,
                      input logic ec, input string req);
    cyc(1'b1, t, 1'b0, 1'b0, 1'b0, ep, es, ec, 1'b1, req);
  endtask

  task automatic idle(input logic ep, input logic es, input string req);
    cyc(1'b0, 12'h000, 1'b0, 1'b0, 1'b0, ep, es, 1'b0, 1'b0, req);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, got hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    cyc(1'b0, 12'h000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R1");

    // queue depth 1, comparator
    smp(12'h500, 1'b0, 1'b0, "R4 equal to high limit sets");
    smp(12'h4B0, 1'b0, 1'b0, "R5 equal to low limit holds");
    smp(12'h4AF, 1'b1, 1'b1, "R5 below low limit clears");

    // queue depth 6, interrupted by a miss and by idle cycles
    fq_code = 2'd3;
    for (int i = 0; i < 5; i++) smp(12'h600, 1'b1, 1'b1, "R2 depth6 not yet");
    smp(12'h4FF, 1'b1, 1'b1, "R3 miss resets count");
    smp(12'h600, 1'b1, 1'b1, "R3 recount 1");
    smp(12'h600, 1'b1, 1'b1, "R3 recount 2");
    idle(1'b1, 1'b1, "R3 idle no effect");
    idle(1'b1, 1'b1, "R3 idle no effect");
    for (int i = 0; i < 3; i++) smp(12'h600, 1'b1, 1'b1, "R3 recount 3-5");
    smp(12'h600, 1'b0, 1'b0, "R2 depth6 sixth sets");

    fq_code = 2'd1;
    smp(12'h4AF, 1'b0, 1'b0, "R2 depth2 first below");
    smp(12'h4AF, 1'b1, 1'b1, "R2 depth2 second clears");

    fq_code = 2'd2;
    for (int i = 0; i < 3; i++) smp(12'h500, 1'b1, 1'b1, "R2 depth4 not yet");
    smp(12'h500, 1'b0, 1'b0, "R2 depth4 fourth sets");
    for (int i = 0; i < 3; i++) smp(12'hFFC, 1'b0, 1'b0, "R5 depth4 below not yet");
    smp(12'hFFC, 1'b1, 1'b1, "R4 negative sample clears");

    // signed limits and single-LSB limit
    fq_code  = 2'd0;
    limit_hi = 12'hFF0;
    limit_lo = 12'hE70;
    smp(12'h800, 1'b1, 1'b1, "R4 most negative below negative high");
    smp(12'h001, 1'b0, 1'b0, "R4 positive above negative high");
    smp(12'h800, 1'b1, 1'b1, "R4 most negative below negative low");
    limit_hi = 12'h501;
    limit_lo = 12'h4B0;
    smp(12'h500, 1'b1, 1'b1, "R4 one LSB under high");
    smp(12'h501, 1'b0, 1'b0, "R4 at high LSB");
    smp(12'h400, 1'b1, 1'b1, "R5 clear");
    limit_hi = 12'h500;

    // polarity
    polarity = 1'b1;
    idle(1'b0, 1'b0, "R9 active-high inactive");
    smp(12'h600, 1'b1, 1'b1, "R9 active-high active");
    polarity = 1'b0;
    idle(1'b0, 1'b0, "R9 active-low active");
    smp(12'h400, 1'b1, 1'b1, "R9 active-low inactive");

    // interrupt mode
    int_mode = 1'b1;
    idle(1'b1, 1'b1, "R6 enter interrupt idle");
    smpc(12'h600, 1'b0, 1'b0, 1'b1, "R8 high event");
    smpc(12'h600, 1'b0, 1'b0, 1'b1, "R6 held while pending");
    cyc(1'b0, 12'h000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R10 read clears pin not status");
    smp(12'h600, 1'b1, 1'b0, "R6 high ignored after clear");
    smp(12'h4B0, 1'b1, 1'b0, "R6 at low not below");
    smpc(12'h400, 1'b0, 1'b1, 1'b0, "R8 low event");
    cyc(1'b0, 12'h000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R6 alert response clears");
    smp(12'h400, 1'b1, 1'b1, "R6 low ignored, high armed");
    smpc(12'h500, 1'b0, 1'b0, 1'b1, "R6 high event again");
    shutdown = 1'b1;
    idle(1'b1, 1'b0, "R7 shutdown entry clears");
    shutdown = 1'b0;
    idle(1'b1, 1'b0, "R7 stays clear");
    smpc(12'h400, 1'b0, 1'b1, 1'b0, "R7 low still armed");
    cyc(1'b0, 12'h000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R6 read clears");

    fq_code = 2'd1;
    smp(12'h500, 1'b1, 1'b1, "R2 interrupt depth2 first");
    smpc(12'h500, 1'b0, 1'b0, 1'b1, "R2 interrupt depth2 second");

    cyc(1'b0, 12'h000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R11 general call");
    smp(12'h400, 1'b1, 1'b1, "R11 high armed after general call");
    smp(12'h400, 1'b1, 1'b1, "R11 high armed after general call");
    int_mode = 1'b0;
    idle(1'b1, 1'b1, "R10 back to comparator");

    @(negedge clk);
    #1;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule